// File: doc/BRIEF.md
# Digital Video Frame Synchronizer (8-bit embedded-sync receive)

This block sits at the receive side of an 8-bit component video link that carries its timing inside the data. Such a link is the byte stream defined by ITU-R BT.656. Each cycle of the pixel clock brings one byte. The block finds the four-byte timing reference codes in that stream and follows the field flag they carry. It locks only at the point where field 1 begins. From the byte after that point it forwards every byte to a capture port, together with a frame-start marker and the current line number. The reference codes themselves are forwarded along with all other bytes.

Software programs the frame length as one total number of lines. That total covers active lines and blanking lines together. Both blanking regions of a field are counted as part of one continuous line sequence, so the vertical flag has no effect on counting. Line 0 is the line that begins at the field-1 boundary, whether or not that line is the first blanking line. When capture is enabled, the block discards input until it sees a real field-1 boundary. Depending on where the stream was at enable time, up to two fields can be lost before that boundary arrives. Lowering the enable clears all lock and history state.

Top module: `vsync_frame_lock`

## Requirements
- R1: A timing reference code is the byte run 0xFF, 0x00, 0x00, XY where bit 7 of XY is 1. In XY, bit 6 is the field flag and bit 4 is set for an end-of-active-video (EAV) code and clear for a start-of-active-video (SAV) code. The other bits have no effect.
- R2: The field flag is taken only from EAV codes. SAV codes never change the tracked field state.
- R3: Lock is gained only when an EAV with field flag 0 directly follows an earlier EAV with field flag 1. Both codes must be received completely while enable is high.
- R4: The bytes before the lock point, including the locking EAV itself, are not forwarded: `out_valid` stays 0 for them. Every input byte after the lock point is forwarded with a one-cycle latency, and this includes reference code bytes.
- R5: `out_frame_start` is 1 together with `out_valid` on the first byte after each field-1 boundary (the byte that follows an F 1-to-0 EAV), and only on that byte. `out_line` is 0 on that byte.
- R6: While locked, the line number advances after each EAV byte XY. The XY byte itself still carries the old line number. After reaching `lines_per_frame`-1, the count returns to 0.
- R7: Each field-1 boundary restarts the line count at 0, even if the programmed length is shorter than the real frame.
- R8: While `enable` is 0, the next clock clears `locked` and `out_valid`, the code history and the known field state. After a later enable, a new full F 1-to-0 transition is required before lock.
- R9: After reset, `locked`, `out_valid` and `out_frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable; low clears lock state |
| lines_per_frame | input | LINE_W | Total lines per frame (active plus blanking) |
| rx_byte | input | 8 | Incoming video byte, one per clock |
| locked | output | 1 | Frame lock has been gained |
| out_valid | output | 1 | Forwarded byte is valid |
| out_byte | output | 8 | Forwarded byte |
| out_frame_start | output | 1 | First forwarded byte of a frame |
| out_line | output | LINE_W | Line number of the forwarded byte |

## Verification
The bench sweeps the enable point across every region of a short synthetic frame, including starts in the middle of reference codes. It checks the exact lock byte arithmetically. A design that locked on any field change or on a partial code would start forwarding a field early. The bench also runs a 525-line frame with enable just after the last field-2 EAV, which forces the full two-field loss. It gives SAV codes an inverted field flag, so a design that sampled SAV codes would lock a line early. A run with a programmed length shorter than the real frame catches a counter that fails to wrap or fails to restart at the field-1 boundary.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
    localparam logic [7:0] SYNC_ONES  = 8'hFF;
    localparam logic [7:0] SYNC_ZEROS = 8'h00;

    typedef struct packed {
        logic hit;   // XY byte of a reference code seen this cycle
        logic eav;   // code is end-of-active-video
        logic fld;   // field flag carried by the code
    } ref_code_t;
endpackage

// File: rtl/vsync_code_detect.sv
module vsync_code_detect
    import vsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [7:0] byte_in,
    output ref_code_t  code
);
    typedef struct packed {
        logic [2:0][7:0] hist;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.hist = '0;
        end else begin
            st_d.hist[2] = st_q.hist[1];
            st_d.hist[1] = st_q.hist[0];
            st_d.hist[0] = byte_in;
        end
        code.hit = !clear && byte_in[7]
                   && (st_q.hist[2] == SYNC_ONES)
                   && (st_q.hist[1] == SYNC_ZEROS)
                   && (st_q.hist[0] == SYNC_ZEROS);
        code.eav = byte_in[4];
        code.fld = byte_in[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vsync_field_edge.sv
module vsync_field_edge
    import vsync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  ref_code_t code,
    output logic      fall
);
    typedef struct packed {
        logic known;
        logic last;
    } fld_state_t;

    fld_state_t st_d, st_q;
    logic       eav_hit;

    always_comb begin
        st_d    = st_q;
        eav_hit = code.hit && code.eav;
        fall    = eav_hit && st_q.known && st_q.last && !code.fld;
        if (clear) begin
            st_d = '0;
        end else if (eav_hit) begin
            st_d.known = 1'b1;
            st_d.last  = code.fld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vsync_line_track.sv
module vsync_line_track #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              restart,
    input  logic              step,
    input  logic [LINE_W-1:0] limit,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

    logic [LINE_W-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (clear || restart) begin
            line_d = '0;
        end else if (step) begin
            if (line_q == limit - ONE) line_d = '0;
            else                       line_d = line_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign line = line_q;
endmodule

// File: rtl/vsync_frame_lock.sv
module vsync_frame_lock
    import vsync_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LINE_W-1:0] lines_per_frame,
    input  logic [7:0]        rx_byte,
    output logic              locked,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_frame_start,
    output logic [LINE_W-1:0] out_line
);
    typedef struct packed {
        logic              locked;
        logic              first;
        logic              valid;
        logic [7:0]        data;
        logic              start;
        logic [LINE_W-1:0] line;
    } top_state_t;

    top_state_t        st_d, st_q;
    ref_code_t         code;
    logic              clear;
    logic              fall;
    logic              step;
    logic [LINE_W-1:0] line_now;

    assign clear = !enable;
    assign step  = st_q.locked && code.hit && code.eav;

    vsync_code_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .byte_in (rx_byte),
        .code    (code)
    );

    vsync_field_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .code  (code),
        .fall  (fall)
    );

    vsync_line_track #(.LINE_W(LINE_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .restart (fall),
        .step    (step),
        .limit   (lines_per_frame),
        .line    (line_now)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = enable && st_q.locked;
        st_d.start = enable && st_q.locked && st_q.first;
        st_d.data  = rx_byte;
        st_d.line  = line_now;
        st_d.first = fall;
        if (clear)     st_d.locked = 1'b0;
        else if (fall) st_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked          = st_q.locked;
    assign out_valid       = st_q.valid;
    assign out_byte        = st_q.data;
    assign out_frame_start = st_q.start;
    assign out_line        = st_q.line;
endmodule

// File: rtl/vsync_frame_lock_chk.sv
module vsync_frame_lock_chk #(
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [LINE_W-1:0] lines_per_frame,
    input logic              locked,
    input logic              out_valid,
    input logic              out_frame_start,
    input logic [LINE_W-1:0] out_line
);
    AST_VALID_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(locked)); // R4
    AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> out_frame_start); // R5
    AST_START_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_start |-> (out_valid && out_line == '0)); // R5
    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lines_per_frame != '0 && $stable(lines_per_frame))
            |-> out_line < lines_per_frame); // R6
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid))
            |-> (out_line == $past(out_line) || out_line == $past(out_line) + 1'b1
                 || out_line == '0)); // R6
    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!locked && !out_valid)); // R8
    AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(enable)); // R3
endmodule

bind vsync_frame_lock vsync_frame_lock_chk #(.LINE_W(LINE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .lines_per_frame (lines_per_frame),
    .locked          (locked),
    .out_valid       (out_valid),
    .out_frame_start (out_frame_start),
    .out_line        (out_line)
);

// File: tb/vsync_frame_lock_tb.sv
module vsync_frame_lock_tb_top;
    localparam int LINE_W = 10;
    localparam int LB     = 20;   // bytes per synthetic line

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [LINE_W-1:0] lines_per_frame = '0;
    logic [7:0]        rx_byte = 8'h10;
    logic              locked, out_valid, out_frame_start;
    logic [7:0]        out_byte;
    logic [LINE_W-1:0] out_line;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    vsync_frame_lock #(.LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .lines_per_frame(lines_per_frame), .rx_byte(rx_byte),
        .locked(locked), .out_valid(out_valid), .out_byte(out_byte),
        .out_frame_start(out_frame_start), .out_line(out_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Field flag of synthetic line g: field 2 is the second half of the frame.
    function automatic bit fld_of(input int g, input int nl);
        return g >= nl / 2;
    endfunction

    // Byte at offset o of line g. Layout: EAV(4), blank(4), SAV(4), active(8).
    // SAV codes carry the inverted field flag on purpose (R2).
    function automatic logic [7:0] byte_at(input int g, input int o, input int nl);
        bit f = fld_of(g, nl);
        case (o)
            0, 8:    return 8'hFF;
            1, 2, 9, 10: return 8'h00;
            3:       return {1'b1, f, 1'b0, 1'b1, 4'h0};
            11:      return {1'b1, ~f, 1'b0, 1'b0, 4'h0};
            4, 6:    return 8'h80;
            5, 7:    return 8'h10;
            default: return 8'h20 + 8'((g + o) & 8'h7F);
        endcase
    endfunction

    // One capture run: disable, program, enable at stream offset 'start'.
    task automatic run(input int nl, input int nprog, input int start, input int frames);
        int fb = nl * LB;
        int k  = (start + LB + fb - 1) / fb;
        int l0 = k * fb + 3;   // XY byte of the first usable field-1 EAV
        bit have_prev = 0;
        bit ev = 0, es = 0;
        int el = 0;
        logic [7:0] eb = '0;
        @(negedge clk);
        enable = 1'b0;
        lines_per_frame = LINE_W'(nprog);
        @(negedge clk);
        check(!locked && !out_valid, "R8", int'(locked), 0);
        enable = 1'b1;
        for (int s = start; s < start + frames * fb; s++) begin
            int p = s % fb;
            int g = p / LB;
            int o = p % LB;
            int ge;
            if (have_prev) begin
                check(out_valid == ev, "R4 valid", int'(out_valid), int'(ev));
                if (ev) begin
                    check(out_byte == eb, "R4 byte", int'(out_byte), int'(eb));
                    check(out_frame_start == es, "R5", int'(out_frame_start), int'(es));
                    check(int'(out_line) == el, "R6/R7 line", int'(out_line), el);
                end else begin
                    check(!out_frame_start, "R3 no start", int'(out_frame_start), 0);
                end
            end
            rx_byte = byte_at(g, o, nl);
            ge = (o >= 4) ? g : ((g == 0) ? nl - 1 : g - 1);
            have_prev = 1;
            ev = (s > l0);
            eb = rx_byte;
            es = ev && g == 0 && o == 4;
            el = ge % nprog;
            @(negedge clk);
        end
        check(out_valid == ev, "R4 last", int'(out_valid), int'(ev));
        enable = 1'b0;
        @(negedge clk);
        check(!locked && !out_valid, "R8 clear", int'(out_valid), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!locked && !out_valid && !out_frame_start, "R9", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!locked && !out_valid, "R9 after release", int'(locked), 0);
        // R1 R2 R3: sweep enable point over a short 12-line frame
        for (int st = 0; st < 12 * LB; st += 5) run(12, 12, st, 3);
        // R7: programmed length shorter than the real frame
        run(12, 5, 37, 3);
        // R6: 525-line frame, enable early in field 1
        run(525, 525, 300, 2);
        // R3: enable just after the last field-2 EAV forces a two-field loss
        run(525, 525, 524 * LB + 10, 3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule